// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block looks up one group of a hashed page table kept in memory. The caller supplies a hash, the table base and table mask, an entry-format select (compact entries of two 32-bit words, or wide entries of two 64-bit words), a compare tag and a flag that marks the search as primary or secondary. On a start pulse the block forms the group address and reads the first word of each of the eight entries in slot order. It stops at the first entry that matches, and then reads that entry's second word.

The block reports hit or miss, the matching slot and the second word, with the requested referenced and changed flags merged in. If the merge alters the stored second word, that word alone is written back. The block does not check protection, does not hold a translation cache, and does not decide whether a secondary search should follow a primary miss. Those jobs belong to the caller.

The memory side is a valid/ready stream. A read request is offered with `rd_valid` and must keep its address and width steady until `rd_ready` accepts it. The block then holds `rsp_ready` high until one response beat arrives on `rsp_valid`. A write is offered with `wr_valid` and stays steady until `wr_ready` accepts it. At most one memory transaction is in flight at any time. Control pins (`start`, `busy`, `done`) and the result pins are plain levels or pulses.

Top module: `pteg_searcher`

## Requirements
- R1: The group address is `tbl_base + ((hash << S) & tbl_mask)`, with S = 7 for wide entries (`fmt64`=1, 16-byte entries) and S = 6 for compact entries (8-byte entries). All reads and writes of a search fall within the eight entries of that group.
- R2: The first word of slot k is read at group address + k*entry size, with k counting up from 0. The scan stops at the first matching slot, so when several slots match, the lowest index is reported.
- R3: Wide format: the first word has valid at bit 0, hash-select at bit 1 and tag in bits 63:7, compared with `cmp_tag[56:0]`. Compact format: the first word is the low 32 bits of `rsp_data`, with valid at bit 31, hash-select at bit 6 and tag {bits 30:7, bits 5:0}, compared with `cmp_tag[29:0]`.
- R4: An entry matches only when it is valid, its hash-select bit equals `secondary` (0 for primary, 1 for secondary), and its tag equals the compare tag.
- R5: On a match, the second word is read at entry address + half the entry size. The result is `hit`=1, `slot_valid`=1, `slot`=matching index, and `word1`=second word with the flags merged (the upper 32 bits are zero in compact format).
- R6: When none of the 8 entries matches, the result is `hit`=0, `slot_valid`=0 and `word1`=0, and no second word is read and nothing is written.
- R7: `set_ref` sets bit 8 and `set_chg` sets bit 7 of the second word. A write of the merged second word to its own address happens only when the merge changes the stored value, and it uses the entry's word width.
- R8: While `rd_valid` or `wr_valid` waits for its ready signal, the request and its address stay unchanged.
- R9: `done` is a one-cycle pulse at the end of each search. `busy` is high from the cycle after `start` until `done`. A `start` while busy is ignored, and so are input changes after the search has started.
- R10: After reset the block is idle, with `busy`, `done`, `hit`, `slot_valid`, `rd_valid` and `wr_valid` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (one-cycle pulse) |
| hash | input | ADDR_W | Hash value selecting the group |
| tbl_base | input | ADDR_W | Byte base address of the table |
| tbl_mask | input | ADDR_W | Mask applied to the group offset |
| fmt64 | input | 1 | 1: wide 16-byte entries, 0: compact 8-byte entries |
| secondary | input | 1 | Search kind compared with hash-select bit |
| cmp_tag | input | 57 | Compare tag (low 30 bits in compact format) |
| set_ref | input | 1 | Set referenced flag (bit 8) on hit |
| set_chg | input | 1 | Set changed flag (bit 7) on hit |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| hit | output | 1 | A matching entry was found |
| slot_valid | output | 1 | `slot` holds a matching index |
| slot | output | 3 | Index of the matching entry |
| word1 | output | 64 | Merged second word of the matching entry |
| rd_valid | output | 1 | Read request offered |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read byte address |
| rd_wide | output | 1 | 1: 64-bit read, 0: 32-bit read |
| rsp_valid | input | 1 | Read data beat present |
| rsp_ready | output | 1 | Block waits for a read beat |
| rsp_data | input | 64 | Read data, right-aligned |
| wr_valid | output | 1 | Write-back offered |
| wr_ready | input | 1 | Write-back accepted |
| wr_addr | output | ADDR_W | Write byte address |
| wr_wide | output | 1 | 1: 64-bit write, 0: 32-bit write |
| wr_data | output | 64 | Write data, right-aligned |

## Verification
The assertions assume that `tbl_base` is aligned to the group size, so that the byte distance from the group address to every request is below eight entries without wrap-around. They also assume that the memory side returns exactly one `rsp_valid` beat for each accepted read and raises it only while `rsp_ready` is high. The stimulus uses an aligned base with a mask that keeps every group inside the modelled memory. The memory model answers each accepted read once, on the next cycle. Ready back-pressure on reads and writes is applied by a fixed cycle pattern, so the hold rules are exercised on most requests.

// File: rtl/pteg_pkg.sv
package pteg_pkg;

  localparam int TAG_W     = 57;
  localparam int TAG32_W   = 30;
  localparam int WORD_W    = 64;
  localparam int SLOTS     = 8;
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int REF_BIT   = 8;
  localparam int CHG_BIT   = 7;
  localparam int SHIFT_WIDE = 7;
  localparam int SHIFT_NARROW = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR_REQ,
    ST_HDR_WAIT,
    ST_LOW_REQ,
    ST_LOW_WAIT,
    ST_WRITE,
    ST_FINISH
  } srch_state_t;

  typedef struct packed {
    logic             valid;
    logic             hsel;
    logic             tag_eq;
  } hdr_view_t;

endpackage

// File: rtl/pteg_addr_gen.sv
module pteg_addr_gen
  import pteg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] hash,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic              fmt64,
  input  logic [SLOT_W-1:0] slot,
  output logic [ADDR_W-1:0] grp_addr,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic [ADDR_W-1:0] low_addr,
  output logic [ADDR_W-1:0] grp_span
);

  localparam int ENT_WIDE   = 16;
  localparam int ENT_NARROW = 8;

  logic [ADDR_W-1:0] grp_off;
  logic [ADDR_W-1:0] ent_off;
  logic [ADDR_W-1:0] half_off;

  always_comb begin
    if (fmt64) begin
      grp_off  = (hash << SHIFT_WIDE) & mask;
      ent_off  = ADDR_W'(slot) * ADDR_W'(ENT_WIDE);
      half_off = ADDR_W'(ENT_WIDE / 2);
      grp_span = ADDR_W'(ENT_WIDE * SLOTS);
    end else begin
      grp_off  = (hash << SHIFT_NARROW) & mask;
      ent_off  = ADDR_W'(slot) * ADDR_W'(ENT_NARROW);
      half_off = ADDR_W'(ENT_NARROW / 2);
      grp_span = ADDR_W'(ENT_NARROW * SLOTS);
    end
    grp_addr = base + grp_off;
    hdr_addr = grp_addr + ent_off;
    low_addr = hdr_addr + half_off;
  end

endmodule

// File: rtl/pteg_entry_decode.sv
module pteg_entry_decode
  import pteg_pkg::*;
(
  input  logic [WORD_W-1:0] word0,
  input  logic              fmt64,
  input  logic              secondary,
  input  logic [TAG_W-1:0]  cmp_tag,
  output hdr_view_t         view,
  output logic              match
);

  logic [TAG32_W-1:0] tag32;

  always_comb begin
    tag32 = {word0[30:7], word0[5:0]};
    if (fmt64) begin
      view.valid  = word0[0];
      view.hsel   = word0[1];
      view.tag_eq = (word0[63:7] == cmp_tag);
    end else begin
      view.valid  = word0[31];
      view.hsel   = word0[6];
      view.tag_eq = (tag32 == cmp_tag[TAG32_W-1:0]);
    end
    match = view.valid && (view.hsel == secondary) && view.tag_eq;
  end

endmodule

// File: rtl/pteg_flag_merge.sv
module pteg_flag_merge
  import pteg_pkg::*;
(
  input  logic [WORD_W-1:0] raw,
  input  logic              fmt64,
  input  logic              set_ref,
  input  logic              set_chg,
  output logic [WORD_W-1:0] clean,
  output logic [WORD_W-1:0] merged,
  output logic              need_wb
);

  logic [WORD_W-1:0] flags;

  always_comb begin
    flags = '0;
    flags[REF_BIT] = set_ref;
    flags[CHG_BIT] = set_chg;
    clean  = fmt64 ? raw : {32'b0, raw[31:0]};
    merged = clean | flags;
    need_wb = (merged != clean);
  end

endmodule

// File: rtl/pteg_searcher.sv
module pteg_searcher
  import pteg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] hash,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] tbl_mask,
  input  logic              fmt64,
  input  logic              secondary,
  input  logic [56:0]       cmp_tag,
  input  logic              set_ref,
  input  logic              set_chg,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic              slot_valid,
  output logic [2:0]        slot,
  output logic [63:0]       word1,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_wide,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [63:0]       rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_wide,
  output logic [63:0]       wr_data
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  srch_state_t       state_q;
  logic [ADDR_W-1:0] hash_q, base_q, mask_q;
  logic              fmt_q, sec_q, ref_q, chg_q;
  logic [TAG_W-1:0]  tag_q;
  logic [SLOT_W-1:0] slot_q;
  logic              hit_q, slotv_q;
  logic [WORD_W-1:0] word1_q;
  logic              wb_q;

  logic [ADDR_W-1:0] grp_addr, hdr_addr, low_addr, grp_span;
  hdr_view_t         view;
  logic              ent_match;
  logic [WORD_W-1:0] w1_clean, w1_merged;
  logic              w1_need_wb;

  pteg_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .hash     (hash_q),
    .base     (base_q),
    .mask     (mask_q),
    .fmt64    (fmt_q),
    .slot     (slot_q),
    .grp_addr (grp_addr),
    .hdr_addr (hdr_addr),
    .low_addr (low_addr),
    .grp_span (grp_span)
  );

  pteg_entry_decode u_dec (
    .word0     (rsp_data),
    .fmt64     (fmt_q),
    .secondary (sec_q),
    .cmp_tag   (tag_q),
    .view      (view),
    .match     (ent_match)
  );

  pteg_flag_merge u_merge (
    .raw     (rsp_data),
    .fmt64   (fmt_q),
    .set_ref (ref_q),
    .set_chg (chg_q),
    .clean   (w1_clean),
    .merged  (w1_merged),
    .need_wb (w1_need_wb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hash_q  <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      fmt_q   <= 1'b0;
      sec_q   <= 1'b0;
      ref_q   <= 1'b0;
      chg_q   <= 1'b0;
      tag_q   <= '0;
      slot_q  <= '0;
      hit_q   <= 1'b0;
      slotv_q <= 1'b0;
      word1_q <= '0;
      wb_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            hash_q  <= hash;
            base_q  <= tbl_base;
            mask_q  <= tbl_mask;
            fmt_q   <= fmt64;
            sec_q   <= secondary;
            ref_q   <= set_ref;
            chg_q   <= set_chg;
            tag_q   <= cmp_tag;
            slot_q  <= '0;
            hit_q   <= 1'b0;
            slotv_q <= 1'b0;
            word1_q <= '0;
            wb_q    <= 1'b0;
            state_q <= ST_HDR_REQ;
          end
        end
        ST_HDR_REQ: begin
          if (rd_ready) state_q <= ST_HDR_WAIT;
        end
        ST_HDR_WAIT: begin
          if (rsp_valid) begin
            if (ent_match) begin
              state_q <= ST_LOW_REQ;
            end else if (slot_q == LAST_SLOT) begin
              state_q <= ST_FINISH;
            end else begin
              slot_q  <= slot_q + 1'b1;
              state_q <= ST_HDR_REQ;
            end
          end
        end
        ST_LOW_REQ: begin
          if (rd_ready) state_q <= ST_LOW_WAIT;
        end
        ST_LOW_WAIT: begin
          if (rsp_valid) begin
            hit_q   <= 1'b1;
            slotv_q <= 1'b1;
            word1_q <= w1_merged;
            wb_q    <= w1_need_wb;
            state_q <= w1_need_wb ? ST_WRITE : ST_FINISH;
          end
        end
        ST_WRITE: begin
          if (wr_ready) state_q <= ST_FINISH;
        end
        ST_FINISH: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state_q != ST_IDLE);
    done      = (state_q == ST_FINISH);
    rd_valid  = (state_q == ST_HDR_REQ) || (state_q == ST_LOW_REQ);
    rd_addr   = (state_q == ST_LOW_REQ) ? low_addr : hdr_addr;
    rd_wide   = fmt_q;
    rsp_ready = (state_q == ST_HDR_WAIT) || (state_q == ST_LOW_WAIT);
    wr_valid  = (state_q == ST_WRITE);
    wr_addr   = low_addr;
    wr_wide   = fmt_q;
    wr_data   = word1_q;
    hit       = hit_q;
    slot_valid = slotv_q;
    slot      = slot_q;
    word1     = word1_q;
  end

  // R8: a stalled read keeps its request and address
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R8: a stalled write keeps its request, address and data
  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R9: done lasts a single cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: every read targets the current group
  p_rd_in_group_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((rd_addr - grp_addr) < grp_span));

  // R7: a write-back follows only a hit that changed the second word
  p_wr_after_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> hit && slot_valid && wb_q);

  // R6: a miss leaves no slot behind
  p_miss_noslot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !hit |-> !slot_valid && (word1 == '0));

  // R4: moving to the second word needs a valid header whose select bit agrees
  p_match_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HDR_WAIT) && rsp_valid && ent_match |-> view.valid && (view.hsel == sec_q));

  // R9: a new search starts only from idle
  p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

endmodule

// File: tb/test_pteg_searcher.sv
module test_pteg_searcher;

  localparam int AW = 12;
  localparam int MEM_BYTES = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          start = 1'b0;
  logic [AW-1:0] hash = '0, tbl_base = '0, tbl_mask = '0;
  logic          fmt64 = 1'b0, secondary = 1'b0, set_ref = 1'b0, set_chg = 1'b0;
  logic [56:0]   cmp_tag = '0;
  logic          busy, done, hit, slot_valid;
  logic [2:0]    slot;
  logic [63:0]   word1;
  logic          rd_valid, rd_wide, rsp_ready, wr_valid, wr_wide;
  logic          rd_ready = 1'b0, wr_ready = 1'b0, rsp_valid = 1'b0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [63:0]   rsp_data = '0, wr_data;

  pteg_searcher #(.ADDR_W(AW)) i_pteg_searcher (
    .clk(clk), .rst_n(rst_n), .start(start), .hash(hash), .tbl_base(tbl_base),
    .tbl_mask(tbl_mask), .fmt64(fmt64), .secondary(secondary), .cmp_tag(cmp_tag),
    .set_ref(set_ref), .set_chg(set_chg), .busy(busy), .done(done), .hit(hit),
    .slot_valid(slot_valid), .slot(slot), .word1(word1), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_wide(rd_wide), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_wide(wr_wide), .wr_data(wr_data)
  );

  logic [7:0] mem [MEM_BYTES];
  int checks = 0;
  int failures = 0;
  int wr_count = 0;
  int cyc = 0;

  function automatic logic [63:0] mem_get(input int a, input logic wide);
    logic [63:0] v = '0;
    int n = wide ? 8 : 4;
    for (int i = 0; i < n; i++) v = (v << 8) | 64'(mem[(a + i) % MEM_BYTES]);
    return v;
  endfunction

  task automatic mem_put(input int a, input logic [63:0] d, input logic wide);
    int n = wide ? 8 : 4;
    for (int i = 0; i < n; i++) mem[(a + i) % MEM_BYTES] = d[8*(n-1-i) +: 8];
  endtask

  // memory model: one response the cycle after an accepted read
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_ready <= (cyc % 3) != 1;
    wr_ready <= (cyc % 4) != 2;
    rsp_valid <= rd_valid && rd_ready;
    if (rd_valid && rd_ready) rsp_data <= mem_get(int'(rd_addr), rd_wide);
    if (wr_valid && wr_ready) begin
      mem_put(int'(wr_addr), wr_data, wr_wide);
      wr_count <= wr_count + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_w0(input logic wide, input logic v, input logic hs,
                                        input logic [56:0] t);
    if (wide) return {t, 5'b0, hs, v};
    return {32'b0, v, t[29:6], hs, t[5:0]};
  endfunction

  task automatic run_case(input logic wide, input logic sec, input int hslot, input int hidx);
    logic [AW-1:0] h, grp;
    logic [56:0] t;
    logic [63:0] w1, w1b, exp_w1;
    int esz, wr0, k;
    logic r, c;
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'h00;
    h = (hidx == 3) ? '1 : AW'(hidx * 37 + 5);
    esz = wide ? 16 : 8;
    grp = 12'h400 + (((wide ? (h << 7) : (h << 6))) & 12'h3FF);
    t = {25'h1ABCDEF ^ 25'(hidx), 32'(hidx * 1234567 + hslot * 77 + 9)};
    w1 = 64'h0123_4567_89AB_CDEF ^ (64'(hidx) << 20);
    w1[8] = hslot[0]; w1[7] = hslot[1];
    if (!wide) w1 = {32'b0, w1[31:0]};
    w1b = w1 ^ 64'h0000_00F0_0F00_0000;
    r = ((hslot + hidx) % 4) >= 2;
    c = ((hslot + hidx) % 2) == 1;
    // decoys before the hit slot (R4)
    for (int s = 0; s < hslot && s < 8; s++) begin
      k = s % 3;
      if (k == 0) mem_put(int'(grp) + s*esz, mk_w0(wide, 1'b0, sec, t), wide);
      else if (k == 1) mem_put(int'(grp) + s*esz, mk_w0(wide, 1'b1, ~sec, t), wide);
      else mem_put(int'(grp) + s*esz, mk_w0(wide, 1'b1, sec, t ^ (57'd1 << ((s*7) % 30))), wide);
      mem_put(int'(grp) + s*esz + esz/2, w1b, wide);
    end
    if (hslot < 8) begin
      mem_put(int'(grp) + hslot*esz, mk_w0(wide, 1'b1, sec, t), wide);
      mem_put(int'(grp) + hslot*esz + esz/2, w1, wide);
    end
    if (hslot < 7) begin // duplicate match at a higher index (R2)
      mem_put(int'(grp) + (hslot+1)*esz, mk_w0(wide, 1'b1, sec, t), wide);
      mem_put(int'(grp) + (hslot+1)*esz + esz/2, w1b, wide);
    end
    // entry just outside the group that would match (R1)
    mem_put((int'(grp) + 8*esz) % MEM_BYTES, mk_w0(wide, 1'b1, sec, t), wide);
    exp_w1 = w1;
    if (r) exp_w1[8] = 1'b1;
    if (c) exp_w1[7] = 1'b1;
    wr0 = wr_count;
    @(negedge clk);
    hash = h; tbl_base = 12'h400; tbl_mask = 12'h3FF; fmt64 = wide; secondary = sec;
    cmp_tag = t; set_ref = r; set_chg = c; start = 1'b1;
    @(negedge clk);
    // R9: start while busy with altered inputs must be ignored
    check("R9 busy after start", 64'(busy), 64'd1);
    secondary = ~sec; hash = ~h; set_ref = 1'b1; set_chg = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    if (hslot < 8) begin
      check("R2 R4 hit", 64'(hit), 64'd1);
      check("R2 slot", 64'(slot), 64'(hslot));
      check("R5 slot_valid", 64'(slot_valid), 64'd1);
      check("R5 R7 word1", word1, exp_w1);
    end else begin
      check("R6 miss hit", 64'(hit), 64'd0);
      check("R6 miss slot_valid", 64'(slot_valid), 64'd0);
      check("R6 miss word1", word1, 64'd0);
    end
    @(negedge clk);
    check("R9 done pulse", 64'(done), 64'd0);
    check("R9 idle after done", 64'(busy), 64'd0);
    @(negedge clk);
    if (hslot < 8) begin
      check("R7 stored word1", mem_get(int'(grp) + hslot*esz + esz/2, wide), exp_w1);
      check("R7 write count", 64'(wr_count - wr0), (exp_w1 != w1) ? 64'd1 : 64'd0);
      check("R3 first word untouched", mem_get(int'(grp) + hslot*esz, wide), mk_w0(wide, 1'b1, sec, t));
    end else begin
      check("R6 no write", 64'(wr_count - wr0), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", 64'(busy), 64'd0);
    check("R10 done", 64'(done), 64'd0);
    check("R10 hit", 64'(hit), 64'd0);
    check("R10 rd_valid", 64'(rd_valid), 64'd0);
    check("R10 wr_valid", 64'(wr_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 slot_valid", 64'(slot_valid), 64'd0);
    for (int f = 0; f < 2; f++)
      for (int sc = 0; sc < 2; sc++)
        for (int s = 0; s <= 8; s++)
          for (int hx = 0; hx < 4; hx++)
            run_case(f[0], sc[0], s, hx);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule